// File: doc/BRIEF.md
# Rectangle Fill and Vertical Scroll Engine

This is a small 2D drawing engine that sits behind a register write port. Software loads an operation code, the corner coordinates, the extents, a foreground colour and a raster-op selector. It then writes the width register, and the engine walks every pixel of the rectangle. For each pixel it reads the current value from a 32-bit-per-pixel frame store, combines it with a new value through the raster op, and writes the result back. The frame store has a fixed line of 2048 pixels, so a pixel address is the row number placed above an 11-bit column.

Two operations exist. A fill draws the foreground colour over the rectangle. A vertical scroll copies a block of source rows to destination rows. The engine picks the row order from the two Y values, so an overlapping move never reads a row it has already overwritten. While a walk runs, a busy flag is high and the parameter registers are locked.

Top module: `rect_scroll_engine`

## Requirements
- R1: Operation code 0x08 fills the rectangle at (base Y, base X) of height x width with the foreground value, combined through the raster op. Each pixel sits at frame-store address {Y[YW-1:0], X[10:0]}, so a line holds 2048 pixels, and columns wrap modulo 2048.
- R2: Operation code 0x0B copies each source pixel (base Y + r, base X + c) to (dest Y + r, dest X + c), combined through the raster op.
- R3: The raster-op register selects the written value: 0x83 writes the new value, 0x85 writes back the old value, and 0x86 writes new XOR old. Its reset value is 0x83.
- R4: Register addresses are 0 operation, 1 base Y, 2 base X, 3 dest Y, 4 dest X, 5 height, 6 foreground, 7 raster op, and 8 width. A write to address 8 stores the width and starts the operation.
- R5: When dest Y > base Y, a scroll walks rows from the bottom up; otherwise it walks from the top down. In both cases the result equals a copy taken from the source before any write.
- R6: Busy rises on the edge that accepts the width write. It stays high for exactly width x height x 2 cycles for a fill and width x height x 3 cycles for a scroll. The frame store is accessed only while busy, and never with a read and a write in the same cycle.
- R7: Register writes made while busy are ignored, including further writes to the width register.
- R8: A width or height of zero leaves busy low and makes no frame-store access.
- R9: Any operation code other than 0x08 or 0x0B leaves busy low and makes no frame-store access.
- R10: After reset, busy is low and no access is made. An operation writes exactly the pixels of its destination rectangle, once each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Operation in progress |
| mem_rd | output | 1 | Frame-store read; data returns on the next cycle |
| mem_wr | output | 1 | Frame-store write |
| mem_addr | output | 22 | Pixel address {row, column} |
| mem_wdata | output | 32 | Pixel write data (red 7:0, green 15:8, blue 23:16) |
| mem_rdata | input | 32 | Pixel read data, one cycle after mem_rd |

## Verification
The assertions check several rules on every cycle:
- no frame-store access happens outside busy;
- a read and a write never occur in the same cycle;
- every write follows a read;
- the locked registers do not move while busy;
- a zero-width start never raises busy.

Other behaviours can only be shown by the bench's scenarios:
- pixel values and the exact set of written addresses;
- the row order chosen for overlapping scrolls, which shows up as an image that differs from a snapshot copy;
- the precise busy length.

For these, a snapshot model is compared against the written image.

// File: rtl/rect_scroll_engine.sv
module rect_scroll_engine #(
  parameter int LINE_PIX = 2048,
  parameter int YW = 11,
  parameter int PW = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic [3:0]                      reg_addr,
  input  logic [PW-1:0]                   reg_wdata,
  output logic                            busy,
  output logic                            mem_rd,
  output logic                            mem_wr,
  output logic [YW+$clog2(LINE_PIX)-1:0]  mem_addr,
  output logic [PW-1:0]                   mem_wdata,
  input  logic [PW-1:0]                   mem_rdata
);
  localparam int XW = $clog2(LINE_PIX);
  localparam int WW = XW + 1;
  localparam logic [3:0] A_OP = 4'd0, A_BY = 4'd1, A_BX = 4'd2, A_DY = 4'd3,
                         A_DX = 4'd4, A_BH = 4'd5, A_FG = 4'd6, A_ROP = 4'd7, A_BW = 4'd8;
  localparam logic [7:0] OP_FILL = 8'h08, OP_SCROLL = 8'h0B;
  localparam logic [7:0] ROP_NEW = 8'h83, ROP_OLD = 8'h85, ROP_XOR = 8'h86;

  typedef enum logic [1:0] {S_IDLE, S_RSRC, S_RDST, S_WR} st_t;

  st_t            st;
  logic [7:0]     op_q, rop_q;
  logic [YW-1:0]  by_q, dy_q, bh_q, row;
  logic [XW-1:0]  bx_q, dx_q;
  logic [WW-1:0]  bw_q, col;
  logic [PW-1:0]  fg_q, src_q;
  logic           down;

  wire is_fill   = (op_q == OP_FILL);
  wire is_scroll = (op_q == OP_SCROLL);
  wire idle      = (st == S_IDLE);
  wire [WW-1:0] new_w = reg_wdata[WW-1:0];
  wire start = reg_wr && idle && (reg_addr == A_BW) && (is_fill || is_scroll)
               && (new_w != '0) && (bh_q != '0);
  wire go_down  = is_scroll && (dy_q > by_q);
  wire last_col = (col == bw_q - 1'b1);
  wire last_row = down ? (row == '0) : (row == bh_q - 1'b1);
  st_t first_st;
  assign first_st = is_scroll ? S_RSRC : S_RDST;

  wire [YW-1:0] src_y = by_q + row;
  wire [XW-1:0] src_x = bx_q + col[XW-1:0];
  wire [YW-1:0] dst_y = (is_fill ? by_q : dy_q) + row;
  wire [XW-1:0] dst_x = (is_fill ? bx_q : dx_q) + col[XW-1:0];

  wire [PW-1:0] new_px = is_fill ? fg_q : src_q;

  assign busy     = !idle;
  assign mem_rd   = (st == S_RSRC) || (st == S_RDST);
  assign mem_wr   = (st == S_WR);
  assign mem_addr = (st == S_RSRC) ? {src_y, src_x} : {dst_y, dst_x};

  always_comb begin
    case (rop_q)
      ROP_NEW: mem_wdata = new_px;
      ROP_OLD: mem_wdata = mem_rdata;
      ROP_XOR: mem_wdata = new_px ^ mem_rdata;
      default: mem_wdata = new_px;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      rop_q <= ROP_NEW;
      by_q  <= '0;
      bx_q  <= '0;
      dy_q  <= '0;
      dx_q  <= '0;
      bh_q  <= '0;
      bw_q  <= '0;
      fg_q  <= '0;
    end else if (reg_wr && idle) begin
      case (reg_addr)
        A_OP:    op_q  <= reg_wdata[7:0];
        A_BY:    by_q  <= reg_wdata[YW-1:0];
        A_BX:    bx_q  <= reg_wdata[XW-1:0];
        A_DY:    dy_q  <= reg_wdata[YW-1:0];
        A_DX:    dx_q  <= reg_wdata[XW-1:0];
        A_BH:    bh_q  <= reg_wdata[YW-1:0];
        A_FG:    fg_q  <= reg_wdata;
        A_ROP:   rop_q <= reg_wdata[7:0];
        A_BW:    bw_q  <= new_w;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      row   <= '0;
      col   <= '0;
      down  <= 1'b0;
      src_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          down <= go_down;
          row  <= go_down ? bh_q - 1'b1 : '0;
          col  <= '0;
          st   <= first_st;
        end
        S_RSRC: st <= S_RDST;
        S_RDST: begin
          src_q <= mem_rdata;
          st    <= S_WR;
        end
        S_WR: begin
          if (last_col) begin
            col <= '0;
            if (last_row) st <= S_IDLE;
            else begin
              row <= down ? row - 1'b1 : row + 1'b1;
              st  <= first_st;
            end
          end else begin
            col <= col + 1'b1;
            st  <= first_st;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rse_checker.sv
module rse_checker #(
  parameter int YW = 11,
  parameter int WW = 12,
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [PW-1:0] reg_wdata,
  input logic [YW-1:0] bh_q,
  input logic [WW-1:0] bw_q,
  input logic [PW-1:0] fg_q
);
  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr));

  a_r6_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r1_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));

  a_r7_height_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (bh_q == $past(bh_q)));

  a_r7_width_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (bw_q == $past(bw_q)));

  a_r7_colour_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fg_q));

  a_r8_zero_width_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && reg_addr == 4'd8 && reg_wdata[WW-1:0] == '0) |=> !busy);
endmodule

bind rect_scroll_engine rse_checker #(.YW(YW), .WW(WW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .bh_q(bh_q), .bw_q(bw_q), .fg_q(fg_q)
);

// File: tb/tb_rect_scroll_engine.sv
module tb_rect_scroll_engine;
  localparam int CLK_NS = 10;
  localparam int YW = 11;
  localparam int XW = 11;
  localparam int AW = YW + XW;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic busy, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  rect_scroll_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  int tests = 0, fails = 0;
  logic [31:0] mem  [int];
  logic [31:0] expm [int];

  function automatic logic [31:0] init_px(int a);
    logic [31:0] v;
    v = 32'(a) * 32'h9E3779B1;
    return v ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] rdm(int a);
    return mem.exists(a) ? mem[a] : init_px(a);
  endfunction
  function automatic logic [31:0] rde(int a);
    return expm.exists(a) ? expm[a] : init_px(a);
  endfunction
  function automatic int paddr(int y, int x);
    return ((y & ((1 << YW) - 1)) << XW) | (x & ((1 << XW) - 1));
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= rdm(int'(mem_addr));
    if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
  end

  // behavioural reference: register mirror, busy countdown, snapshot image
  int m_op, m_by, m_bx, m_dy, m_dx, m_bh, m_fg, m_rop, cnt;

  function automatic logic [31:0] mrop(logic [31:0] nv, logic [31:0] ov, int r);
    if (r == 'h85) return ov;
    if (r == 'h86) return nv ^ ov;
    return nv;
  endfunction

  function automatic void apply_op(int w);
    logic [31:0] snap [int];
    for (int r = 0; r < m_bh; r++)
      for (int c = 0; c < w; c++)
        snap[r * 4096 + c] = (m_op == 8) ? 32'(m_fg) : rde(paddr(m_by + r, m_bx + c));
    for (int r = 0; r < m_bh; r++)
      for (int c = 0; c < w; c++) begin
        int a;
        a = (m_op == 8) ? paddr(m_by + r, m_bx + c) : paddr(m_dy + r, m_dx + c);
        expm[a] = mrop(snap[r * 4096 + c], rde(a), m_rop);
      end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_op = 0; m_by = 0; m_bx = 0; m_dy = 0; m_dx = 0; m_bh = 0; m_fg = 0;
      m_rop = 'h83; cnt = 0;
    end else if (cnt > 0) begin
      cnt--;
    end else if (reg_wr) begin
      case (reg_addr)
        0: m_op = int'(reg_wdata[7:0]);
        1: m_by = int'(reg_wdata[10:0]);
        2: m_bx = int'(reg_wdata[10:0]);
        3: m_dy = int'(reg_wdata[10:0]);
        4: m_dx = int'(reg_wdata[10:0]);
        5: m_bh = int'(reg_wdata[10:0]);
        6: m_fg = int'(reg_wdata);
        7: m_rop = int'(reg_wdata[7:0]);
        8: begin
          int w;
          w = int'(reg_wdata[11:0]);
          if ((m_op == 8 || m_op == 'h0B) && w != 0 && m_bh != 0) begin
            apply_op(w);
            cnt = w * m_bh * ((m_op == 8) ? 2 : 3);
          end
        end
        default: ;
      endcase
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison of busy and port quietness against the model
  always @(negedge clk) if (rst_n) begin
    check(busy == (cnt > 0), "R6", "busy", longint'(busy), longint'(cnt > 0));
    if (cnt == 0)
      check(!mem_rd && !mem_wr, "R6", "access while idle", longint'({mem_rd, mem_wr}), 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wait_idle();
    while (busy || cnt > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_image(string req);
    foreach (mem[k]) begin
      check(expm.exists(k), req, "unexpected write", k, -1);
      if (expm.exists(k)) check(mem[k] == expm[k], req, "pixel", mem[k], expm[k]);
    end
    foreach (expm[k]) check(mem.exists(k), req, "missing write", -1, k);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL R6 watchdog: busy actual=%0d expected=0", busy);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy, "R10", "reset busy", longint'(busy), 0);
    check(!mem_rd && !mem_wr, "R10", "reset access", longint'({mem_rd, mem_wr}), 0);

    // R1 R3 fill with rop new
    wr(0, 8); wr(1, 2); wr(2, 5); wr(5, 3); wr(6, 'h00123456); wr(7, 'h83); wr(8, 4);
    wait_idle(); cmp_image("R1");
    // R3 xor fill
    wr(7, 'h86); wr(6, 'h00FF00FF); wr(1, 3); wr(2, 4); wr(8, 5);
    wait_idle(); cmp_image("R3");
    // R3 keep old
    wr(7, 'h85); wr(6, 'h00ABCDEF); wr(1, 8); wr(8, 3);
    wait_idle(); cmp_image("R3");
    // R2 R5 scroll upwards with overlap
    wr(7, 'h83); wr(0, 'h0B); wr(1, 6); wr(2, 1); wr(3, 3); wr(4, 1); wr(5, 5); wr(8, 6);
    wait_idle(); cmp_image("R2");
    // R5 scroll downwards with overlap
    wr(1, 2); wr(3, 4); wr(8, 6);
    wait_idle(); cmp_image("R5");
    // R5 xor scroll downwards
    wr(7, 'h86); wr(1, 1); wr(3, 2); wr(5, 4); wr(8, 3);
    wait_idle(); cmp_image("R5");
    // R8 zero width and zero height
    wr(7, 'h83); wr(8, 0);
    repeat (3) @(negedge clk);
    check(!busy, "R8", "zero width busy", longint'(busy), 0);
    wr(5, 0); wr(8, 4);
    repeat (3) @(negedge clk);
    check(!busy, "R8", "zero height busy", longint'(busy), 0);
    cmp_image("R8");
    // R9 unsupported code
    wr(5, 2); wr(0, 4); wr(8, 4);
    repeat (3) @(negedge clk);
    check(!busy, "R9", "bad op busy", longint'(busy), 0);
    cmp_image("R9");
    // R7 writes while busy are ignored; R4 width alone restarts
    wr(0, 8); wr(1, 20); wr(2, 1); wr(5, 2); wr(6, 'h000000AA); wr(8, 3);
    wr(5, 7); wr(6, 'h00FFFFFF); wr(8, 9);
    wait_idle();
    wr(2, 10); wr(8, 2);
    wait_idle(); cmp_image("R7");
    // R1 R10 right edge of a line
    wr(1, 30); wr(2, 2044); wr(6, 'h00010203); wr(8, 4);
    wait_idle(); cmp_image("R10");
    check(!busy, "R4", "final idle", longint'(busy), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule